// File: doc/BRIEF.md
# DMA Transfer Count Bank

This block keeps the remaining-transfer counters of a four-channel DMA controller. Software loads each channel's count through a small register slave. The slave takes full 32-bit writes or writes to either 16-bit half alone. Each time the DMA engine completes one transfer on a channel, it pulses that channel's done strobe, and the block decrements the count. When the count runs out, the block raises a one-cycle terminal-count flag.

Only the count field is stored, 24 bits wide. A loaded value of zero stands for the largest run, 2^24 transfers. Channel 2 also holds a source-address pair: a saved initial value and a current value that the engine advances. When a control bit is set, the current source address goes back to the saved value at that channel's terminal count. This lets a transfer repeat from the same source.

Register index map (word indices on `bus_addr`):
- 0 to 3: the counts of channels 0 to 3.
- 4 to 7: the controls of channels 0 to 3, with bit 0 as the reload enable.
- 8: the channel 2 initial source address.
- 9: the channel 2 current source address.
- Any other index reads as zero.

Top module: `dma_tc_bank`

## Requirements
- R1: After reset, every control register, every terminal-count flag, the read data and both channel 2 source registers are zero.
- R2: A channel loaded with a count n from 1 upward raises its terminal-count flag on the n-th done strobe and on no earlier strobe.
- R3: A loaded count of 0 counts as 2^24 transfers: one strobe takes it to 0xFFFFFF without a terminal-count flag.
- R4: Bits 31:24 of every count register read as 0, and write data in those bits is ignored.
- R5: `bus_be` bit 0 enables bits 15:0 and bit 1 enables bits 31:16. A half that is not enabled keeps its previous value.
- R6: A read at index c (0 to 3) returns channel c's remaining count on `bus_rdata` one cycle after `bus_rd` is sampled.
- R7: The terminal-count flag is high for exactly one cycle: the cycle after the edge at which a strobe takes the count from 1 to 0. In that same cycle the count reads 0.
- R8: When a bus write and a done strobe reach the same channel in one cycle, the written value is kept, the strobe is lost and no flag is raised.
- R9: Control bit 0 (reload enable) can be set only for channel 2. On channels 0, 1 and 3 it always reads 0.
- R10: With channel 2's reload enabled, the current source address equals the saved initial value in the same cycle that channel 2's flag is high. With reload disabled, the current source address is left unchanged.
- R11: `src2_upd` loads `src2_next` into the channel 2 current source address. A bus write to index 9 takes priority over a reload, and a reload takes priority over an engine update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write request |
| bus_rd | input | 1 | Register read request |
| bus_addr | input | 4 | Register word index |
| bus_be | input | 2 | Half enables: bit 0 selects bits 15:0, bit 1 selects bits 31:16 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| xfer_done | input | 4 | Per-channel transfer-done strobes |
| tc_flag | output | 4 | Per-channel terminal-count pulses |
| src2_next | input | 32 | Next source address for channel 2 from the engine |
| src2_upd | input | 1 | Load strobe for `src2_next` |
| src2_addr | output | 32 | Channel 2 current source address |

## Verification
The assertions check the following on every cycle:
- each strobe steps the count down by exactly one;
- the flag coincides with a zero count and never lasts two cycles;
- a full write wins over a simultaneous strobe;
- a half write keeps the other half;
- count reads carry zero upper bits;
- control reads of the channels without reload return zero;
- the source reload and the engine update land with the right priority.

Some behaviours can only be shown by the bench's scenarios. These are the exact strobe count to the flag for a sweep of loaded values on every channel, the wrap of a zero count to 0xFFFFFF, the merged value built by a sequence of half writes, and the source address seen on the port when the flag fires with reload enabled and disabled.

// File: rtl/dma_tc_pkg.sv
package dma_tc_pkg;
  localparam int BUS_W  = 32;
  localparam int HALF_W = BUS_W / 2;

  // Merge write data into an old register value under the half enables.
  function automatic logic [BUS_W-1:0] merge_halves(input logic [BUS_W-1:0] old_v,
                                                    input logic [BUS_W-1:0] new_v,
                                                    input logic [1:0]       be);
    logic [BUS_W-1:0] r;
    r[HALF_W-1:0]     = be[0] ? new_v[HALF_W-1:0]     : old_v[HALF_W-1:0];
    r[BUS_W-1:HALF_W] = be[1] ? new_v[BUS_W-1:HALF_W] : old_v[BUS_W-1:HALF_W];
    return r;
  endfunction
endpackage

// File: rtl/dma_tc_chan.sv
module dma_tc_chan #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tc_evt_o,
  output logic             tc_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             tc_q;

  // Count field: no reset value, software loads it before use.
  always_ff @(posedge clk) begin
    if (wr_i)       cnt_q <= wdata_i;
    else if (dec_i) cnt_q <= cnt_q - ONE;
  end

  assign tc_evt_o = dec_i && !wr_i && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) tc_q <= 1'b0;
    else     tc_q <= tc_evt_o;
  end

  assign cnt_o = cnt_q;
  assign tc_o  = tc_q;

  // R2/R3: each accepted strobe steps the count down by one, modulo 2^CNT_W
  a_r3_dec_step: assert property (@(posedge clk) disable iff (rst)
    (dec_i && !wr_i) |=> (cnt_q == $past(cnt_q) - ONE));
  // R7: the flag coincides with a zero count
  a_r7_tc_at_zero: assert property (@(posedge clk) disable iff (rst)
    tc_q |-> (cnt_q == '0));
  // R7: the flag is a single-cycle pulse
  a_r7_tc_single: assert property (@(posedge clk) disable iff (rst)
    tc_q |=> !tc_q);
  // R8: a write wins over a simultaneous strobe
  a_r8_wr_wins: assert property (@(posedge clk) disable iff (rst)
    (wr_i && dec_i) |=> (cnt_q == $past(wdata_i) && !tc_q));
endmodule

// File: rtl/dma_tc_ctrl.sv
module dma_tc_ctrl #(
  parameter bit HAS_RELOAD = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_i,
  input  logic bit_i,
  output logic en_o
);
  generate
    if (HAS_RELOAD) begin : g_reg
      logic en_q;
      always_ff @(posedge clk) begin
        if (rst)       en_q <= 1'b0;
        else if (wr_i) en_q <= bit_i;
      end
      assign en_o = en_q;
    end else begin : g_tie
      logic unused_w;
      assign unused_w = clk ^ rst ^ wr_i ^ bit_i;
      assign en_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/dma_tc_srcreload.sv
module dma_tc_srcreload #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_wr_i,
  input  logic [ADDR_W-1:0] init_d_i,
  input  logic              cur_wr_i,
  input  logic [ADDR_W-1:0] cur_d_i,
  input  logic              upd_i,
  input  logic [ADDR_W-1:0] next_i,
  input  logic              tc_evt_i,
  input  logic              en_i,
  output logic [ADDR_W-1:0] init_o,
  output logic [ADDR_W-1:0] cur_o
);
  logic [ADDR_W-1:0] init_q, cur_q;
  logic              reload_w;

  assign reload_w = tc_evt_i && en_i;

  always_ff @(posedge clk) begin
    if (rst)            init_q <= '0;
    else if (init_wr_i) init_q <= init_d_i;
  end

  always_ff @(posedge clk) begin
    if (rst)           cur_q <= '0;
    else if (cur_wr_i) cur_q <= cur_d_i;
    else if (reload_w) cur_q <= init_q;
    else if (upd_i)    cur_q <= next_i;
  end

  assign init_o = init_q;
  assign cur_o  = cur_q;

  // R10: terminal count with reload enabled restores the saved address
  a_r10_reload: assert property (@(posedge clk) disable iff (rst)
    (tc_evt_i && en_i && !cur_wr_i) |=> (cur_q == $past(init_q)));
  // R10: without reload, a terminal count alone leaves the address
  a_r10_no_reload: assert property (@(posedge clk) disable iff (rst)
    (tc_evt_i && !en_i && !cur_wr_i && !upd_i) |=> $stable(cur_q));
  // R11: engine update applies when nothing of higher priority is present
  a_r11_update: assert property (@(posedge clk) disable iff (rst)
    (upd_i && !cur_wr_i && !(tc_evt_i && en_i)) |=> (cur_q == $past(next_i)));
endmodule

// File: rtl/dma_tc_bank.sv
module dma_tc_bank #(
  parameter int NCH       = 4,
  parameter int CNT_W     = 24,
  parameter int RELOAD_CH = 2,
  parameter int SADDR_W   = 32,
  parameter int IDX_W     = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             bus_wr,
  input  logic                             bus_rd,
  input  logic [IDX_W-1:0]                 bus_addr,
  input  logic [1:0]                       bus_be,
  input  logic [dma_tc_pkg::BUS_W-1:0]     bus_wdata,
  output logic [dma_tc_pkg::BUS_W-1:0]     bus_rdata,
  input  logic [NCH-1:0]                   xfer_done,
  output logic [NCH-1:0]                   tc_flag,
  input  logic [SADDR_W-1:0]               src2_next,
  input  logic                             src2_upd,
  output logic [SADDR_W-1:0]               src2_addr
);
  import dma_tc_pkg::*;

  localparam int CTRL_BASE = NCH;
  localparam int INIT_IDX  = 2 * NCH;
  localparam int CUR_IDX   = 2 * NCH + 1;
  localparam int PAD_W     = BUS_W - CNT_W;
  localparam int SPAD_W    = BUS_W - SADDR_W;

  logic [CNT_W-1:0] cnt_w   [NCH];
  logic [BUS_W-1:0] cnt_mrg [NCH];
  logic [NCH-1:0]   cnt_wr, ctrl_wr, ctrl_en, tc_evt;
  logic [SADDR_W-1:0] init_w, cur_w;
  logic [BUS_W-1:0] init_mrg, cur_mrg;
  logic             init_wr, cur_wr;
  logic [BUS_W-1:0] rd_mux;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign cnt_wr[c]  = bus_wr && (bus_addr == IDX_W'(c));
      assign ctrl_wr[c] = bus_wr && (bus_addr == IDX_W'(CTRL_BASE + c)) && bus_be[0];
      assign cnt_mrg[c] = merge_halves({{PAD_W{1'b0}}, cnt_w[c]}, bus_wdata, bus_be);

      dma_tc_chan #(.CNT_W(CNT_W)) u_chan (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (cnt_wr[c]),
        .wdata_i  (cnt_mrg[c][CNT_W-1:0]),
        .dec_i    (xfer_done[c]),
        .cnt_o    (cnt_w[c]),
        .tc_evt_o (tc_evt[c]),
        .tc_o     (tc_flag[c])
      );

      dma_tc_ctrl #(.HAS_RELOAD(c == RELOAD_CH)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr_i  (ctrl_wr[c]),
        .bit_i (bus_wdata[0]),
        .en_o  (ctrl_en[c])
      );
    end
  endgenerate

  assign init_wr  = bus_wr && (bus_addr == IDX_W'(INIT_IDX));
  assign cur_wr   = bus_wr && (bus_addr == IDX_W'(CUR_IDX));
  assign init_mrg = merge_halves({{SPAD_W{1'b0}}, init_w}, bus_wdata, bus_be);
  assign cur_mrg  = merge_halves({{SPAD_W{1'b0}}, cur_w},  bus_wdata, bus_be);

  dma_tc_srcreload #(.ADDR_W(SADDR_W)) u_src (
    .clk       (clk),
    .rst       (rst),
    .init_wr_i (init_wr),
    .init_d_i  (init_mrg[SADDR_W-1:0]),
    .cur_wr_i  (cur_wr),
    .cur_d_i   (cur_mrg[SADDR_W-1:0]),
    .upd_i     (src2_upd),
    .next_i    (src2_next),
    .tc_evt_i  (tc_evt[RELOAD_CH]),
    .en_i      (ctrl_en[RELOAD_CH]),
    .init_o    (init_w),
    .cur_o     (cur_w)
  );

  assign src2_addr = cur_w;

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == IDX_W'(c))             rd_mux = {{PAD_W{1'b0}}, cnt_w[c]};
      if (bus_addr == IDX_W'(CTRL_BASE + c)) rd_mux = {{(BUS_W-1){1'b0}}, ctrl_en[c]};
    end
    if (bus_addr == IDX_W'(INIT_IDX)) rd_mux = {{SPAD_W{1'b0}}, init_w};
    if (bus_addr == IDX_W'(CUR_IDX))  rd_mux = {{SPAD_W{1'b0}}, cur_w};
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R4: count reads never carry upper bits
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr < IDX_W'(NCH))) |=> (bus_rdata[BUS_W-1:CNT_W] == '0));
  // R9: control reads of channels without reload return zero
  a_r9_ctrl_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr >= IDX_W'(CTRL_BASE)) && (bus_addr < IDX_W'(2 * NCH))
     && (bus_addr != IDX_W'(CTRL_BASE + RELOAD_CH))) |=> (bus_rdata == '0));
  // R5: a low-half write keeps the upper count bits
  a_r5_half_keep: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (bus_addr == '0) && (bus_be == 2'b01) && !xfer_done[0])
    |=> (cnt_w[0][CNT_W-1:HALF_W] == $past(cnt_w[0][CNT_W-1:HALF_W])));
endmodule

// File: tb/sim_dma_tc_bank.sv
module sim_dma_tc_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [1:0]  bus_be = 2'b11;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  xfer_done = '0;
  logic [3:0]  tc_flag;
  logic [31:0] src2_next = '0;
  logic        src2_upd = 1'b0;
  logic [31:0] src2_addr;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;  // 250 MHz

  dma_tc_bank u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .xfer_done(xfer_done), .tc_flag(tc_flag), .src2_next(src2_next),
    .src2_upd(src2_upd), .src2_addr(src2_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [1:0] be);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 2'b11;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic strobe(input int ch);
    @(negedge clk);
    xfer_done[ch] = 1'b1;
    @(negedge clk);
    xfer_done[ch] = 1'b0;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 tc", {28'd0, tc_flag}, 32'd0);
    check("R1 rdata", bus_rdata, 32'd0);
    check("R1 src", src2_addr, 32'd0);
    rd(4'd6, v); check("R1 ctrl2", v, 32'd0);
    rd(4'd8, v); check("R1 init", v, 32'd0);

    // R2/R6/R7: sweep counts 1..6 on every channel
    for (int ch = 0; ch < 4; ch++) begin
      for (int n = 1; n <= 6; n++) begin
        wr(4'(ch), 32'(n), 2'b11);
        for (int k = 1; k <= n; k++) begin
          strobe(ch);
          check("R7 tc", {28'd0, tc_flag}, (k == n) ? 32'(1 << ch) : 32'd0);
          if (k == n) begin
            @(negedge clk);
            check("R7 pulse", {28'd0, tc_flag}, 32'd0);
          end
          rd(4'(ch), v);
          check("R6 remaining", v, 32'(n - k));
        end
      end
    end

    // R2: channels counting together with distinct loads
    for (int ch = 0; ch < 4; ch++) wr(4'(ch), 32'(ch + 2), 2'b11);
    for (int k = 1; k <= 5; k++) begin
      logic [3:0] expt;
      expt = '0;
      @(negedge clk);
      xfer_done = 4'hF;
      @(negedge clk);
      xfer_done = 4'h0;
      for (int ch = 0; ch < 4; ch++) if (k == ch + 2) expt[ch] = 1'b1;
      check("R2 parallel", {28'd0, tc_flag}, {28'd0, expt});
    end

    // R3: zero means maximum, wraps to all ones
    wr(4'd1, 32'd0, 2'b11);
    strobe(1);
    check("R3 no tc", {28'd0, tc_flag}, 32'd0);
    rd(4'd1, v); check("R3 wrap", v, 32'h00FF_FFFF);

    // R4: upper byte ignored
    wr(4'd3, 32'hAB12_3456, 2'b11);
    rd(4'd3, v); check("R4 upper", v, 32'h0012_3456);

    // R5: half merges
    wr(4'd0, 32'h00AA_BBCC, 2'b11);
    wr(4'd0, 32'h9999_1111, 2'b01);
    rd(4'd0, v); check("R5 low", v, 32'h00AA_1111);
    wr(4'd0, 32'hFF77_2222, 2'b10);
    rd(4'd0, v); check("R5 high", v, 32'h0077_1111);

    // R8: write wins over strobe, even at count 1
    wr(4'd2, 32'd1, 2'b11);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'd2; bus_wdata = 32'd7; xfer_done[2] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; xfer_done[2] = 1'b0;
    check("R8 no tc", {28'd0, tc_flag}, 32'd0);
    rd(4'd2, v); check("R8 value", v, 32'd7);

    // R9: reload bit only on channel 2
    for (int ch = 0; ch < 4; ch++) begin
      wr(4'(4 + ch), 32'd1, 2'b11);
      rd(4'(4 + ch), v);
      check("R9 ctrl", v, (ch == 2) ? 32'd1 : 32'd0);
    end

    // R11: engine update and bus write of the current source
    wr(4'd8, 32'h0000_1000, 2'b11);
    wr(4'd9, 32'h0000_2000, 2'b11);
    @(negedge clk);
    src2_upd = 1'b1; src2_next = 32'h0000_2004;
    @(negedge clk);
    src2_upd = 1'b0;
    check("R11 update", src2_addr, 32'h0000_2004);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'd9; bus_wdata = 32'h0000_3000; src2_upd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; src2_upd = 1'b0;
    check("R11 bus priority", src2_addr, 32'h0000_3000);

    // R10: reload at terminal count, same cycle as the flag
    wr(4'd2, 32'd2, 2'b11);
    strobe(2);
    check("R10 before", src2_addr, 32'h0000_3000);
    strobe(2);
    check("R10 tc", {28'd0, tc_flag}, 32'h4);
    check("R10 reload", src2_addr, 32'h0000_1000);

    // R10: reload disabled leaves address
    wr(4'd6, 32'd0, 2'b11);
    wr(4'd9, 32'h0000_5000, 2'b11);
    wr(4'd2, 32'd1, 2'b11);
    strobe(2);
    check("R10 tc off", {28'd0, tc_flag}, 32'h4);
    check("R10 kept", src2_addr, 32'h0000_5000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule